// File: doc/BRIEF.md
# Flash Page Read Buffer with Next-Page Prefetch

This block sits between a read requester and a slow flash array read port. It keeps a small set of full-width pages (128 bits each by default). Each page has a page-address tag and a valid flag. A request whose page is already held gets its answer one cycle after it is accepted. The array is not touched. A request whose page is not held starts one array read. The returned page is answered and written into the buffer that was filled longest ago. After a normal demand access, the block fetches the following page ahead of use if that page is not already held.

A non-zero timing-emulation code on a request makes the buffers invisible to that request. It always goes to the array and never starts a prefetch. If the request is also flagged as non-sequential, every buffer is invalidated first. This keeps the stretched access timing exact. The requester accepts one request at a time through a ready/valid pair. The array side is a single-cycle read strobe with a page address, answered later by a one-cycle data-valid pulse.

Top module: `pgbuf_prefetch`

## Requirements
- R1: After reset no page is held, `req_ready` is 1, and `rsp_valid` and `ary_rd_en` are 0. The first request therefore misses.
- R2: The page of a request is `req_addr[ADDR_W-1:4]`. A request with emulation code 0 whose page is held is a hit. It gives `rsp_valid` with the held data in the cycle after acceptance, and no array read is made for it.
- R3: On a miss, `ary_rd_en` pulses for exactly one cycle in the cycle after acceptance, with `ary_page` equal to the request page. `rsp_valid` rises, carrying `ary_rdata`, in the cycle after the clock edge that samples `ary_rvalid`.
- R4: A new page is written into the buffer filled longest ago. Hits do not change this order.
- R5: Take a demand access to page P with emulation code 0, where page P+1 is not held once the demand fill is done. The block issues one prefetch read of P+1 in the cycle in which the demand `rsp_valid` rises, and stores the result. A later request to P+1 then hits.
- R6: No prefetch is issued when page P+1 is already held.
- R7: A request with a non-zero emulation code misses even when its page is held.
- R8: A request with a non-zero emulation code issues no prefetch.
- R9: A request with a non-zero emulation code and `req_seq` = 0 invalidates every buffer. With `req_seq` = 1 the buffers are kept.
- R10: `req_ready` is 1 only while no access is in progress. It is 0 from the acceptance of a miss until its answer, and 0 throughout a prefetch.
- R11: Writing a page that is already held rewrites that same buffer instead of taking a second one, and marks it as the newest fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_seq | input | 1 | Request continues the previous access sequentially |
| req_emu | input | EMU_W | Timing-emulation code, 0 for normal operation |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | DATA_W | Read data |
| ary_rd_en | output | 1 | Array read strobe, one cycle |
| ary_page | output | ADDR_W-4 | Page address of the array read |
| ary_rvalid | input | 1 | Array read data valid, one cycle |
| ary_rdata | input | DATA_W | Array read data |

## Verification
The bench builds the block with its default parameters: four buffers, 24-bit addresses, 128-bit pages and a 5-bit emulation code. The array model answers three cycles after each strobe. With only four buffers, a dozen requests cycle the whole fill order more than once. Among them is a sequence in which fill-order replacement and replacement on most recent use would evict different pages, so the miss/hit outcome tells the two apart. The same small set makes it cheap to reach an eviction of page P+1 by the demand fill of page P, which a flush followed by refill also exercises.

// File: rtl/pgbuf_pkg.sv
// Shared types for the page read buffer.
// Assumes: nothing beyond the enum below is shared between modules.
package pgbuf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request
        ST_DREQ,   // demand read strobe
        ST_DWAIT,  // waiting for demand data
        ST_PREQ,   // prefetch read strobe
        ST_PWAIT   // waiting for prefetch data
    } pb_state_e;
endpackage

// File: rtl/pgbuf_match.sv
// Tag comparator: finds the buffer holding a given page.
// Assumes at most one valid buffer carries any tag; excl masks entries out.
module pgbuf_match #(
    parameter int NBUF  = 4,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic [NBUF-1:0][TAG_W-1:0] tags,
    input  logic [NBUF-1:0]            valid,
    input  logic [NBUF-1:0]            excl,
    input  logic [TAG_W-1:0]           key,
    output logic [NBUF-1:0]            hit_vec,
    output logic                       hit_any,
    output logic [IDX_W-1:0]           hit_idx
);
    // one comparator per buffer
    for (genvar i = 0; i < NBUF; i++) begin : g_cmp
        assign hit_vec[i] = valid[i] && !excl[i] && (tags[i] == key);
    end

    assign hit_any = |hit_vec;

    // encode the one-hot match into an index
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/pgbuf_age.sv
// Fill-order list: each buffer has an age, 0 = newest fill.
// Assumes NBUF is a power of two; ages form a permutation at all times.
module pgbuf_age #(
    parameter int NBUF = 4,
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    output logic [IDX_W-1:0] victim_idx
);
    logic [NBUF-1:0][IDX_W-1:0] age;

    // age update: filled entry becomes newest, younger ones grow one older
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBUF; i++) age[i] <= IDX_W'(NBUF - 1 - i);
        end else if (fill_en) begin
            for (int i = 0; i < NBUF; i++) begin
                if (IDX_W'(i) == fill_idx) age[i] <= '0;
                else if (age[i] < age[fill_idx]) age[i] <= age[i] + 1'b1;
            end
        end
    end

    // victim is the entry with the oldest age
    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (age[i] == IDX_W'(NBUF - 1)) victim_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pgbuf_store.sv
// Page storage: data, tag and valid flag per buffer.
// Assumes flush and fill never coincide; fill wins if they do.
module pgbuf_store #(
    parameter int NBUF   = 4,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 128,
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            fill_idx,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic [DATA_W-1:0]           fill_data,
    output logic [NBUF-1:0][TAG_W-1:0]  tags,
    output logic [NBUF-1:0][DATA_W-1:0] data,
    output logic [NBUF-1:0]             valid
);
    for (genvar i = 0; i < NBUF; i++) begin : g_ent
        // valid flag: cleared by reset or flush, set by a fill
        always_ff @(posedge clk) begin
            if (!rst_n) valid[i] <= 1'b0;
            else if (fill_en && fill_idx == IDX_W'(i)) valid[i] <= 1'b1;
            else if (flush) valid[i] <= 1'b0;
        end

        // tag and data written on a fill
        always_ff @(posedge clk) begin
            if (fill_en && fill_idx == IDX_W'(i)) begin
                tags[i] <= fill_tag;
                data[i] <= fill_data;
            end
        end
    end
endmodule

// File: rtl/pgbuf_prefetch.sv
// Page read buffer with next-page prefetch, in front of a flash read port.
// Serves hits from buffers, fetches misses from the array, prefetches P+1.
// A non-zero emulation code bypasses hits and prefetch and, when the
// request is non-sequential, flushes all buffers.
// Assumes the array answers each strobe with exactly one ary_rvalid pulse.
module pgbuf_prefetch
    import pgbuf_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 128,
    parameter int EMU_W  = 5,
    localparam int OFS_W = $clog2(DATA_W / 8),
    localparam int TAG_W = ADDR_W - OFS_W,
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq,
    input  logic [EMU_W-1:0]  req_emu,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              ary_rd_en,
    output logic [TAG_W-1:0]  ary_page,
    input  logic              ary_rvalid,
    input  logic [DATA_W-1:0] ary_rdata
);
    pb_state_e state;
    logic [TAG_W-1:0] cur_page;
    logic             cur_emu;

    logic [NBUF-1:0][TAG_W-1:0]  buf_tag;
    logic [NBUF-1:0][DATA_W-1:0] buf_data;
    logic [NBUF-1:0]             buf_valid;

    logic [TAG_W-1:0] req_page, key_a, key_b;
    logic [NBUF-1:0]  hit_vec_a, hit_vec_b, excl_b;
    logic             hit_a, hit_b;
    logic [IDX_W-1:0] idx_a, idx_b, victim_idx, fill_idx;
    logic             accept, emu_nz, flush, fill_en, demand_fill;
    logic [OFS_W-1:0] unused_ofs;

    assign req_page   = req_addr[ADDR_W-1:OFS_W];
    assign unused_ofs = req_addr[OFS_W-1:0];
    assign emu_nz     = |req_emu;
    assign req_ready  = (state == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign flush      = accept && emu_nz && !req_seq;

    // lookup keys: the page itself and the page after it
    assign key_a = req_ready ? req_page : cur_page;
    assign key_b = key_a + 1'b1;

    assign demand_fill = (state == ST_DWAIT) && ary_rvalid;
    assign fill_en     = demand_fill || ((state == ST_PWAIT) && ary_rvalid);
    // a demand fill reuses a buffer already holding the page, else the victim
    assign fill_idx    = (demand_fill && hit_a) ? idx_a : victim_idx;

    // next-page check ignores the buffer the demand fill is about to overwrite
    always_comb begin
        excl_b = '0;
        if (demand_fill) excl_b[fill_idx] = 1'b1;
    end

    pgbuf_match #(.NBUF(NBUF), .TAG_W(TAG_W)) u_match_a (
        .tags(buf_tag), .valid(buf_valid), .excl('0), .key(key_a),
        .hit_vec(hit_vec_a), .hit_any(hit_a), .hit_idx(idx_a)
    );

    pgbuf_match #(.NBUF(NBUF), .TAG_W(TAG_W)) u_match_b (
        .tags(buf_tag), .valid(buf_valid), .excl(excl_b), .key(key_b),
        .hit_vec(hit_vec_b), .hit_any(hit_b), .hit_idx(idx_b)
    );

    pgbuf_age #(.NBUF(NBUF)) u_age (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_idx(fill_idx),
        .victim_idx(victim_idx)
    );

    pgbuf_store #(.NBUF(NBUF), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fill_en(fill_en),
        .fill_idx(fill_idx),
        .fill_tag((state == ST_PWAIT) ? cur_page + 1'b1 : cur_page),
        .fill_data(ary_rdata), .tags(buf_tag), .data(buf_data), .valid(buf_valid)
    );

    // array strobe driven straight from the state register
    assign ary_rd_en = (state == ST_DREQ) || (state == ST_PREQ);
    assign ary_page  = (state == ST_PREQ) ? cur_page + 1'b1 : cur_page;

    // access sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_page  <= '0;
            cur_emu   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) begin
                    cur_page <= req_page;
                    cur_emu  <= emu_nz;
                    if (!emu_nz && hit_a) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= buf_data[idx_a];
                        state     <= hit_b ? ST_IDLE : ST_PREQ;
                    end else begin
                        state <= ST_DREQ;
                    end
                end
                ST_DREQ: state <= ST_DWAIT;
                ST_DWAIT: if (ary_rvalid) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= ary_rdata;
                    state     <= (!cur_emu && !hit_b) ? ST_PREQ : ST_IDLE;
                end
                ST_PREQ: state <= ST_PWAIT;
                ST_PWAIT: if (ary_rvalid) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgbuf_prefetch_chk.sv
// Property checker for pgbuf_prefetch, attached by bind.
// Assumes it sees the top's ports plus the valid flags and the page match.
module pgbuf_prefetch_chk #(
    parameter int NBUF  = 4,
    parameter int EMU_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_seq,
    input logic [EMU_W-1:0] req_emu,
    input logic             rsp_valid,
    input logic             ary_rd_en,
    input logic [NBUF-1:0]  buf_valid,
    input logic [NBUF-1:0]  hit_vec_a
);
    logic       emu_flag;
    logic [1:0] rd_cnt;

    // counts array strobes since the last accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emu_flag <= 1'b0;
            rd_cnt   <= '0;
        end else if (req_valid && req_ready) begin
            emu_flag <= |req_emu;
            rd_cnt   <= '0;
        end else if (ary_rd_en && rd_cnt != 2'd3) begin
            rd_cnt <= rd_cnt + 1'b1;
        end
    end

    p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ary_rd_en |=> !ary_rd_en);

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ary_rd_en |-> !req_ready);

    p_emu_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && |req_emu) |=> !rsp_valid);

    p_emu_nopf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_flag && ary_rd_en) |-> (rd_cnt == 2'd0));

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && |req_emu && !req_seq) |=> (buf_valid == '0));

    p_unique_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec_a));
endmodule

bind pgbuf_prefetch pgbuf_prefetch_chk #(.NBUF(NBUF), .EMU_W(EMU_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_seq(req_seq), .req_emu(req_emu), .rsp_valid(rsp_valid),
    .ary_rd_en(ary_rd_en), .buf_valid(buf_valid), .hit_vec_a(hit_vec_a)
);

// File: tb/tb_pgbuf_prefetch.sv
`timescale 1ns/1ps
// Directed bench: one task per request scenario, array modelled at 3 cycles.
module tb_pgbuf_prefetch;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 128;
    localparam int TAG_W  = ADDR_W - 4;
    localparam int LAT    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_seq = 1'b0;
    logic [4:0]        req_emu = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              ary_rd_en;
    logic [TAG_W-1:0]  ary_page;
    logic              ary_rvalid = 1'b0;
    logic [DATA_W-1:0] ary_rdata = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pgbuf_prefetch dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_seq(req_seq), .req_emu(req_emu),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ary_rd_en(ary_rd_en),
        .ary_page(ary_page), .ary_rvalid(ary_rvalid), .ary_rdata(ary_rdata)
    );

    function automatic logic [DATA_W-1:0] pat(input logic [TAG_W-1:0] p);
        return {32'h5A00_0000 ^ 32'(p), 32'hC3C3_0000 ^ 32'(p),
                ~32'(p), 32'(p) * 32'd7};
    endfunction

    // array model: answers each strobe LAT cycles later, driven at negedge
    logic [TAG_W-1:0] m_page;
    int               m_cnt = 0;
    always @(negedge clk) begin
        ary_rvalid <= 1'b0;
        if (m_cnt != 0) begin
            m_cnt <= m_cnt - 1;
            if (m_cnt == 1) begin
                ary_rvalid <= 1'b1;
                ary_rdata  <= pat(m_page);
            end
        end
        if (rst_n && ary_rd_en) begin
            m_page <= ary_page;
            m_cnt  <= LAT;
        end
    end

    task automatic check(input string rq, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // issue one request and check reads, response data and timing
    task automatic run_req(input string rq, input logic [TAG_W-1:0] page,
                           input logic seq, input logic [4:0] emu,
                           input int exp_nrd, input logic [TAG_W-1:0] p0,
                           input logic [TAG_W-1:0] p1);
        int nrd = 0, nrsp = 0, rsp_cyc = 0, rd_cyc = 0;
        logic [TAG_W-1:0] pages [2];
        logic [DATA_W-1:0] got = '0;
        logic ready1 = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {page, 4'h9};
        req_seq   = seq;
        req_emu   = emu;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 1; cyc < 40; cyc++) begin
            if (cyc == 1) ready1 = req_ready;
            if (rsp_valid) begin
                nrsp++;
                got = rsp_data;
                if (rsp_cyc == 0) rsp_cyc = cyc;
            end
            if (ary_rd_en) begin
                if (nrd < 2) pages[nrd] = ary_page;
                if (nrd == 0) rd_cyc = cyc;
                nrd++;
            end
            if (req_ready && cyc > 1) break;
            if (req_ready && cyc == 1 && !ary_rd_en) break;
            @(negedge clk);
        end
        check(rq, "array reads", 128'(nrd), 128'(exp_nrd));
        check(rq, "responses", 128'(nrsp), 128'd1);
        check(rq, "data", got, pat(page));
        if (exp_nrd >= 1 && nrd >= 1) check(rq, "first read page", 128'(pages[0]), 128'(p0));
        if (exp_nrd == 2 && nrd == 2) check(rq, "prefetch page", 128'(pages[1]), 128'(p1));
        if (emu == 0 && exp_nrd >= 1 && p0 != page) begin
            check(rq, "hit timing", 128'(rsp_cyc), 128'd1);
        end else if (exp_nrd >= 1 && p0 == page) begin
            check({rq, " R3"}, "strobe cycle", 128'(rd_cyc), 128'd1);
            check({rq, " R3"}, "answer cycle", 128'(rsp_cyc), 128'(LAT + 2));
            check({rq, " R10"}, "busy ready", 128'(ready1), 128'd0);
        end else begin
            check(rq, "hit timing", 128'(rsp_cyc), 128'd1);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "ready", 128'(req_ready), 128'd1);
        check("R1", "rsp_valid", 128'(rsp_valid), 128'd0);
        check("R1", "ary_rd_en", 128'(ary_rd_en), 128'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        // R1 R3 R5: first access misses, then prefetches page 1
        run_req("R1_R5", 20'h0, 1'b0, 5'd0, 2, 20'h0, 20'h1);
        // R2 R5: hit on prefetched page 1, prefetch 2
        run_req("R2_R5", 20'h1, 1'b1, 5'd0, 1, 20'h2, 20'h0);
        run_req("R2", 20'h2, 1'b1, 5'd0, 1, 20'h3, 20'h0);
        // R6: page 2 held, no prefetch
        run_req("R6", 20'h1, 1'b1, 5'd0, 0, 20'h0, 20'h0);
        // R4: page 0x40 evicts page 0 (oldest fill), 0x41 evicts page 1
        run_req("R4", 20'h40, 1'b0, 5'd0, 2, 20'h40, 20'h41);
        // R4: page 1 was hit last but still evicted
        run_req("R4_miss", 20'h1, 1'b0, 5'd0, 2, 20'h1, 20'h2);
        // R7 R8 R11: emulated request to held page misses, no prefetch, no flush
        run_req("R7_R8", 20'h41, 1'b1, 5'd3, 1, 20'h41, 20'h0);
        // R9 seq kept buffers: page 2 hits, prefetch 3 evicts 0x40
        run_req("R9_seq", 20'h2, 1'b1, 5'd0, 1, 20'h3, 20'h0);
        // R11: page 0x41 still in one buffer, prefetch 0x42
        run_req("R11", 20'h41, 1'b1, 5'd0, 1, 20'h42, 20'h0);
        // R9: non-sequential emulated request flushes all
        run_req("R9_flush", 20'h1, 1'b0, 5'd5, 1, 20'h1, 20'h0);
        run_req("R9_after", 20'h3, 1'b0, 5'd0, 2, 20'h3, 20'h4);
        run_req("R2_refill", 20'h1, 1'b1, 5'd0, 1, 20'h2, 20'h0);
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule